// File: doc/BRIEF.md
# Multithreaded Fetch Thread Selector

This block decides, every cycle, which of several hardware thread contexts may use the fetch slot. It looks at how many instructions each thread has waiting ahead of issue, whether each thread has an outstanding second-level cache miss or a first-level data miss, and which threads are running. From these inputs it produces a one-hot fetch grant. When the selected policy calls for it, it also produces a one-cycle request to release a thread's in-flight resources.

A mode input chooses the policy. The modes are: fewest-waiting-instructions priority; plain rotation; priority with miss stall; priority with miss stall plus a release request; and an adaptive mode. The adaptive mode either blocks or only demotes threads with a data miss, depending on how many threads are running. Ties are broken by a rotating pointer, so equal threads take turns. The release request is only a pulse. The pipeline acts on it elsewhere.

Top module: `fetch_thread_sel`

## Requirements
- R1: In mode 0 (occupancy), the granted thread has a pre-issue count no larger than that of any other active thread. Thread i's count is occ[i*6 +: 6].
- R2: Ties in the occupancy-based modes go to the first tied candidate in the order ptr, ptr+1, ..., wrapping. The pointer is 0 after reset. After any nonzero grant to thread g it becomes g+1, wrapping to 0. A zero grant leaves it unchanged.
- R3: In mode 1 (rotate), counts are ignored. The grant goes to the first active thread at or after the pointer.
- R4: In mode 2 (stall), a thread with l2_miss high is never granted. It competes again as soon as its miss flag drops.
- R5: In mode 3 (release), L2-missing threads are blocked as in R4. A rising edge of l2_miss on an active thread raises that thread's flush_req bit.
- R6: flush_req is high only in mode 3. It lasts a single cycle per miss event; a new event needs the miss flag to drop and rise again.
- R7: In mode 4 (adaptive), when at most FEW_MAX threads are active (default 2), a thread with l1d_miss high is never granted.
- R8: In mode 4 with more than FEW_MAX active threads, an l1d_miss thread is granted only when every active thread misses. l2_miss has no effect in mode 4.
- R9: An inactive thread is never granted and never flushed. With no eligible thread the grant is all zeros.
- R10: While rst_n is low, grant and flush_req are zero.
- R11: At most one grant bit is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 3 | Policy: 0 occupancy, 1 rotate, 2 stall, 3 release, 4 adaptive, others as 0 |
| active | input | NTHR | Thread running flags |
| occ | input | NTHR*CNT_W | Packed per-thread pre-issue instruction counts |
| l2_miss | input | NTHR | Outstanding L2 miss per thread |
| l1d_miss | input | NTHR | Outstanding L1 data miss per thread |
| grant | output | NTHR | One-hot fetch grant, same cycle as inputs |
| flush_req | output | NTHR | One-cycle resource release request |

## Verification
Some properties are checked on every cycle: a single grant bit, grants and flushes only to active threads, minimum count in occupancy mode, no grant to L2-missing threads under stall or release, and no grant to L1-missing threads under adaptive gating. Release pulses are checked never to last two cycles. Only the bench's scenarios can show the pointer order: the rotation and tie results depend on the history of grants. The same holds for the fallback to missing threads when all threads miss, for the re-arming of a release request after a miss clears, and for the pointer returning to zero after reset.

// File: rtl/fts_pkg.sv
package fts_pkg;
  typedef enum logic [2:0] {
    MODE_OCC    = 3'd0,
    MODE_ROTATE = 3'd1,
    MODE_STALL  = 3'd2,
    MODE_FLUSH  = 3'd3,
    MODE_ADAPT  = 3'd4
  } fetch_mode_e;

  // number of set bits in a vector of up to 32 threads
  function automatic int count_set(input logic [31:0] v);
    int n;
    n = 0;
    for (int i = 0; i < 32; i++) n += int'(v[i]);
    return n;
  endfunction

  // (base + step) modulo n, for base < n and step < n
  function automatic int wrap_add(input int base, input int step, input int n);
    int s;
    s = base + step;
    if (s >= n) s -= n;
    return s;
  endfunction
endpackage

// File: rtl/fts_elig.sv
module fts_elig #(
  parameter int NTHR    = 4,
  parameter int FEW_MAX = 2
) (
  input  logic [2:0]      mode,
  input  logic [NTHR-1:0] active,
  input  logic [NTHR-1:0] l2_miss,
  input  logic [NTHR-1:0] l1d_miss,
  output logic [NTHR-1:0] cand,
  output logic            ignore_cnt,
  output logic            few_thr
);
  import fts_pkg::*;

  logic [NTHR-1:0] clean;

  assign few_thr = count_set(32'(active)) <= FEW_MAX;
  assign clean   = active & ~l1d_miss;

  always_comb begin
    ignore_cnt = 1'b0;
    case (fetch_mode_e'(mode))
      MODE_ROTATE: begin
        cand       = active;
        ignore_cnt = 1'b1;
      end
      MODE_STALL, MODE_FLUSH: cand = active & ~l2_miss;
      MODE_ADAPT: begin
        if (few_thr)            cand = clean;
        else if (clean != '0)   cand = clean;
        else                    cand = active;
      end
      default: cand = active;
    endcase
  end
endmodule

// File: rtl/fts_pick.sv
module fts_pick #(
  parameter int NTHR  = 4,
  parameter int CNT_W = 6,
  localparam int PTR_W = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic [NTHR-1:0]       cand,
  input  logic [NTHR*CNT_W-1:0] occ,
  input  logic                  ignore_cnt,
  input  logic [PTR_W-1:0]      ptr,
  output logic [NTHR-1:0]       pick,
  output logic                  any,
  output logic [PTR_W-1:0]      win_idx
);
  import fts_pkg::*;

  logic [CNT_W-1:0] best_cnt;
  logic [CNT_W-1:0] cur_cnt;
  int               pos;

  always_comb begin
    any      = 1'b0;
    best_cnt = '0;
    win_idx  = '0;
    cur_cnt  = '0;
    pos      = 0;
    for (int k = 0; k < NTHR; k++) begin
      pos     = wrap_add(int'(ptr), k, NTHR);
      cur_cnt = ignore_cnt ? '0 : occ[pos*CNT_W +: CNT_W];
      if (cand[pos] && (!any || cur_cnt < best_cnt)) begin
        any      = 1'b1;
        best_cnt = cur_cnt;
        win_idx  = PTR_W'(pos);
      end
    end
    pick = '0;
    if (any) pick[win_idx] = 1'b1;
  end
endmodule

// File: rtl/fts_flush.sv
module fts_flush #(
  parameter int NTHR = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [NTHR-1:0] active,
  input  logic [NTHR-1:0] l2_miss,
  output logic [NTHR-1:0] miss_rise,
  output logic [NTHR-1:0] req
);
  logic [NTHR-1:0] l2_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) l2_prev <= '0;
    else        l2_prev <= l2_miss;
  end

  assign miss_rise = l2_miss & ~l2_prev;
  assign req       = (en && rst_n) ? (miss_rise & active) : '0;
endmodule

// File: rtl/fetch_thread_sel.sv
module fetch_thread_sel #(
  parameter int NTHR    = 4,
  parameter int CNT_W   = 6,
  parameter int FEW_MAX = 2,
  localparam int PTR_W  = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2:0]            mode,
  input  logic [NTHR-1:0]       active,
  input  logic [NTHR*CNT_W-1:0] occ,
  input  logic [NTHR-1:0]       l2_miss,
  input  logic [NTHR-1:0]       l1d_miss,
  output logic [NTHR-1:0]       grant,
  output logic [NTHR-1:0]       flush_req
);
  import fts_pkg::*;

  // named internal events
  logic [NTHR-1:0]  cand;
  logic             ignore_cnt;
  logic             few_thr;
  logic [NTHR-1:0]  pick;
  logic             any_pick;
  logic [PTR_W-1:0] win_idx;
  logic [PTR_W-1:0] rr_ptr;
  logic [NTHR-1:0]  miss_rise;
  logic             flush_en;

  fts_elig #(.NTHR(NTHR), .FEW_MAX(FEW_MAX)) u_elig (
    .mode(mode), .active(active), .l2_miss(l2_miss), .l1d_miss(l1d_miss),
    .cand(cand), .ignore_cnt(ignore_cnt), .few_thr(few_thr)
  );

  fts_pick #(.NTHR(NTHR), .CNT_W(CNT_W)) u_pick (
    .cand(cand), .occ(occ), .ignore_cnt(ignore_cnt), .ptr(rr_ptr),
    .pick(pick), .any(any_pick), .win_idx(win_idx)
  );

  assign flush_en = fetch_mode_e'(mode) == MODE_FLUSH;

  fts_flush #(.NTHR(NTHR)) u_flush (
    .clk(clk), .rst_n(rst_n), .en(flush_en), .active(active),
    .l2_miss(l2_miss), .miss_rise(miss_rise), .req(flush_req)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        rr_ptr <= '0;
    else if (any_pick) rr_ptr <= (win_idx == PTR_W'(NTHR-1)) ? '0 : win_idx + 1'b1;
  end

  assign grant = rst_n ? pick : '0;
endmodule

// File: rtl/fts_checker.sv
module fts_checker #(
  parameter int NTHR    = 4,
  parameter int CNT_W   = 6,
  parameter int FEW_MAX = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [2:0]            mode,
  input logic [NTHR-1:0]       active,
  input logic [NTHR*CNT_W-1:0] occ,
  input logic [NTHR-1:0]       l2_miss,
  input logic [NTHR-1:0]       l1d_miss,
  input logic [NTHR-1:0]       grant,
  input logic [NTHR-1:0]       flush_req
);
  logic min_ok;
  logic few_chk;
  logic [CNT_W-1:0] g_cnt;

  always_comb begin
    g_cnt = '0;
    for (int i = 0; i < NTHR; i++)
      if (grant[i]) g_cnt = occ[i*CNT_W +: CNT_W];
    min_ok = 1'b1;
    for (int j = 0; j < NTHR; j++)
      if (active[j] && occ[j*CNT_W +: CNT_W] < g_cnt) min_ok = 1'b0;
    few_chk = 1'b1;
    if ($countones(active) > FEW_MAX) few_chk = 1'b0;
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R11
  AST_GRANT_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~active) == '0); // R9
  AST_FLUSH_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req & ~active) == '0); // R9
  AST_OCC_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0 && grant != '0) |-> min_ok); // R1
  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd2 || mode == 3'd3) |-> (grant & l2_miss) == '0); // R4
  AST_FLUSH_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 3'd3) |-> flush_req == '0); // R6
  AST_FLUSH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req != '0) |=> (flush_req & $past(flush_req)) == '0); // R6
  AST_FLUSH_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req & ~l2_miss) == '0); // R5
  AST_ADAPT_FEW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4 && few_chk) |-> (grant & l1d_miss) == '0); // R7
  AST_ADAPT_MANY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4 && !few_chk && (active & ~l1d_miss) != '0)
      |-> (grant & l1d_miss) == '0); // R8
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (grant == '0 && flush_req == '0)); // R10
endmodule

bind fetch_thread_sel fts_checker #(.NTHR(NTHR), .CNT_W(CNT_W), .FEW_MAX(FEW_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .active(active), .occ(occ),
  .l2_miss(l2_miss), .l1d_miss(l1d_miss), .grant(grant), .flush_req(flush_req)
);

// File: tb/fetch_thread_sel_bench.sv
module fetch_thread_sel_bench;
  localparam int NTHR  = 4;
  localparam int CNT_W = 6;
  localparam int NV    = 15;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode = '0;
  logic [3:0] active = '0, l2 = '0, l1 = '0;
  logic [23:0] occ = '0;
  logic [3:0] grant, flush_req;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fetch_thread_sel #(.NTHR(NTHR), .CNT_W(CNT_W), .FEW_MAX(2)) u_fetch_thread_sel (
    .clk(clk), .rst_n(rst_n), .mode(mode), .active(active), .occ(occ),
    .l2_miss(l2), .l1d_miss(l1), .grant(grant), .flush_req(flush_req)
  );

  // {mode, active, l2, l1, {c3,c2,c1,c0}, exp grant, exp flush}; run in order from reset
  localparam logic [46:0] VEC [NV] = '{
    {3'd0,4'b1111,4'b0000,4'b0000,{6'd3,6'd7,6'd3,6'd5},4'b0010,4'b0000}, // R1 min, tie to lowest
    {3'd0,4'b1111,4'b0000,4'b0000,{6'd4,6'd4,6'd4,6'd4},4'b0100,4'b0000}, // R2 ptr=2
    {3'd0,4'b1111,4'b0000,4'b0000,{6'd4,6'd4,6'd4,6'd4},4'b1000,4'b0000}, // R2 ptr=3
    {3'd1,4'b1110,4'b0000,4'b0000,{6'd1,6'd9,6'd9,6'd0},4'b0010,4'b0000}, // R3 counts ignored
    {3'd1,4'b1111,4'b0000,4'b0000,{6'd0,6'd0,6'd0,6'd0},4'b0100,4'b0000}, // R3 rotation
    {3'd2,4'b1111,4'b0001,4'b0000,{6'd6,6'd2,6'd5,6'd0},4'b0100,4'b0000}, // R4 stall, no flush
    {3'd3,4'b1111,4'b0011,4'b0000,{6'd5,6'd5,6'd1,6'd0},4'b1000,4'b0010}, // R5 pulse on new miss
    {3'd3,4'b1111,4'b0011,4'b0000,{6'd5,6'd5,6'd1,6'd0},4'b0100,4'b0000}, // R6 held miss
    {3'd3,4'b0111,4'b1011,4'b0000,{6'd5,6'd5,6'd1,6'd0},4'b0100,4'b0000}, // R9 inactive no flush
    {3'd4,4'b0011,4'b1111,4'b0001,{6'd0,6'd0,6'd8,6'd0},4'b0010,4'b0000}, // R7 few stall
    {3'd4,4'b0111,4'b0000,4'b0011,{6'd0,6'd9,6'd0,6'd0},4'b0100,4'b0000}, // R8 demote
    {3'd4,4'b0111,4'b0000,4'b0111,{6'd0,6'd3,6'd2,6'd4},4'b0010,4'b0000}, // R8 all miss fallback
    {3'd4,4'b0011,4'b0000,4'b0011,{6'd1,6'd1,6'd1,6'd1},4'b0000,4'b0000}, // R9 none eligible
    {3'd0,4'b0000,4'b0000,4'b0000,{6'd1,6'd1,6'd1,6'd1},4'b0000,4'b0000}, // R9 none active
    {3'd0,4'b1111,4'b0000,4'b0000,{6'd1,6'd1,6'd1,6'd1},4'b0100,4'b0000}  // R2 ptr held
  };
  localparam string TAG [NV] = '{"R1","R2","R2","R3","R3","R4","R5","R6",
                                 "R9","R7","R8","R8","R9","R9","R2"};

  task automatic chk(input string tag, input string what,
                     input logic [3:0] got, input logic [3:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%b exp=%b", tag, what, got, exp);
    end
  endtask

  task automatic drive(input logic [2:0] m, input logic [3:0] a, input logic [3:0] m2,
                       input logic [3:0] m1, input logic [23:0] c);
    mode = m; active = a; l2 = m2; l1 = m1; occ = c;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog (all requirements) got=hung exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // reset: a live flush mode with a rising miss still yields nothing (R10)
    drive(3'd3, 4'b1111, 4'b0001, 4'b0000, {6'd1,6'd1,6'd1,6'd1});
    repeat (3) @(negedge clk);
    #2;
    chk("R10", "grant in reset", grant, 4'b0000);
    chk("R10", "flush in reset", flush_req, 4'b0000);

    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][46:44], VEC[i][43:40], VEC[i][39:36], VEC[i][35:32], VEC[i][31:8]);
      #2;
      chk(TAG[i], $sformatf("vec%0d grant", i), grant, VEC[i][7:4]);
      chk(TAG[i], $sformatf("vec%0d flush", i), flush_req, VEC[i][3:0]);
      @(negedge clk);
    end

    // pointer now 3, miss history clear: flush re-arm sequence (R5, R6)
    drive(3'd3, 4'b1111, 4'b0100, 4'b0000, {6'd1,6'd1,6'd1,6'd1});
    #2; chk("R5", "rise grant", grant, 4'b1000);
    chk("R5", "rise flush", flush_req, 4'b0100);
    @(negedge clk); #2;
    chk("R6", "held flush", flush_req, 4'b0000);
    chk("R2", "wrap to 0", grant, 4'b0001);
    @(negedge clk); l2 = 4'b0000; #2;
    chk("R6", "cleared flush", flush_req, 4'b0000);
    chk("R2", "next ptr", grant, 4'b0010);
    @(negedge clk); l2 = 4'b0100; #2;
    chk("R6", "re-arm flush", flush_req, 4'b0100);
    chk("R5", "missing skipped", grant, 4'b1000);

    // stall until resolution (R4); pointer now 0
    @(negedge clk);
    drive(3'd2, 4'b1111, 4'b0001, 4'b0000, {6'd5,6'd5,6'd5,6'd0});
    #2; chk("R4", "stalled thread skipped", grant, 4'b0010);
    chk("R6", "no flush in stall", flush_req, 4'b0000);
    @(negedge clk); l2 = 4'b0000; #2;
    chk("R4", "resolved thread wins", grant, 4'b0001);

    // reset mid-run returns pointer to 0 (R10, R2)
    @(negedge clk);
    rst_n = 1'b0;
    drive(3'd0, 4'b1111, 4'b0000, 4'b0000, {6'd2,6'd2,6'd2,6'd2});
    #2; chk("R10", "grant during reset", grant, 4'b0000);
    @(negedge clk); rst_n = 1'b1; #2;
    chk("R2", "ptr reset to 0", grant, 4'b0001);

    @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule